// File: doc/BRIEF.md
# Five-Pin GPIO Controller with Register-Bit Monitor

This block runs five general purpose pins from a small register file on the host register bus. Each register address holds one 16-bit word. Each pin has a direction bit. An output pin drives the value of its level bit. For an input pin, the level bit takes the pin's logic level after a two-flop synchronizer. Host writes to level bits only take effect for output pins.

A single global switch puts all five pins into monitor mode together. In this mode each level bit mirrors one bit of a separate byte-wide register space. That space is reached through a simple read port with one cycle of latency. Each pin has a link entry that names the byte address and the bit index to follow. A scanner visits the five link entries in turn, one read per clock. It refreshes only the level bit that belongs to the returned read. Output pins therefore drive internal status bits without any software involvement.

The host register port decodes one word per address and reads without delay. The contents of the indirect space sit outside this block.

Top module: `gpio_mon`

## Requirements
- R1: Reset clears all direction bits, all level bits, the monitor enable and all link entries. Every register then reads 0 and pin_oe is 0.
- R2: The control word is at address 0x20. Bits [4:0] are the levels, bits [12:8] are the directions and bit 15 is the monitor enable. pin_oe equals the direction bits, and an output pin drives its level bit on pin_out.
- R3: A host write to the control word changes a pin's level bit only when that pin was already an output before the write and monitor mode was off. The write is ignored in every other case, and the level read back stays unchanged.
- R4: When monitor mode is off, an input pin's level bit reads the pin value sampled three rising edges after the pin changes. The value still reads as the old one after two edges.
- R5: Link entries for pins 0 to 4 sit at addresses 0x21 to 0x25. Bits [7:0] hold the byte address and bits [10:8] hold the bit index. Both fields read back as written, and bits [15:11] read as 0.
- R6: Bits 5 to 7, 13 and 14 of the control word always read as 0. Addresses outside 0x20 to 0x25 read as 0, and writes to those addresses change no register.
- R7: ind_addr presents the byte address of link entries 0, 1, 2, 3, 4, 0, ... in that order, moving on one entry every clock.
- R8: While monitor mode is on, pin k's level bit takes bit[index_k] of the byte returned at ind_rdata one clock after entry k's address was presented. The other level bits do not change.
- R9: Clearing the monitor enable stops the mirroring. Output-pin levels then hold their last mirrored value, and input pins go back to following their pins.
- R10: In monitor mode, an output pin drives the mirrored bit on pin_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_addr | input | 8 | Host register address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for reg_addr, no latency |
| ind_addr | output | 8 | Byte address presented to the indirect space |
| ind_rdata | input | 8 | Byte returned one clock after ind_addr |
| pin_in | input | 5 | Sampled pin levels |
| pin_out | output | 5 | Pin drive values |
| pin_oe | output | 5 | Pin output enables |

## Verification
The monitor function is tried with a table of link and byte patterns. The patterns place the chosen bit at index 0, at index 7 and at inner positions, and pair a byte that has only that bit set with a byte that has only that bit clear. A bit taken from the wrong position, or a byte taken from a neighbouring address, shows up as a wrong level. Other rows point two pins at the same byte through different bits, rewrite one address with its complement, and use addresses 0x00 and 0xFF. Failures in pin-to-entry routing and in address-width handling are told apart that way. Directed tests cover write gating by direction and by monitor state, the synchronizer latency, the scan order, the unused bits and addresses, and leaving monitor mode.

// File: rtl/gpio_mon_pkg.sv
package gpio_mon_pkg;

   // register file hit classes
   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_CTRL = 2'd1,
      HIT_LINK = 2'd2
   } reg_hit_e;

   // wrap-around increment for a small round-robin pointer
   function automatic int unsigned rr_next(input int unsigned cur, input int unsigned count);
      return (cur + 1 >= count) ? 0 : cur + 1;
   endfunction

endpackage

// File: rtl/gpio_mon_sync.sv
module gpio_mon_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 0) begin : g_bad_stages
      $error("gpio_mon_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stage_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q <= '0;
         end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
               stage_q[s] <= stage_q[s-1];
            end
         end
      end

      assign q_o = stage_q[STAGES-1];
   end

endmodule

// File: rtl/gpio_mon_regs.sv
module gpio_mon_regs
   import gpio_mon_pkg::*;
#(
   parameter int NPIN      = 5,
   parameter int REG_W     = 16,
   parameter int RADDR_W   = 8,
   parameter int IND_AW    = 8,
   parameter int BIT_W     = 3,
   parameter int CTRL_ADDR = 'h20,
   parameter int LINK_BASE = 'h21,
   parameter int LVL_LSB   = 0,
   parameter int DIR_LSB   = 8,
   parameter int MON_BIT   = 15
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en_i,
   input  logic [RADDR_W-1:0]           addr_i,
   input  logic [REG_W-1:0]             wdata_i,
   output logic [REG_W-1:0]             rdata_o,
   input  logic [NPIN-1:0]              level_i,
   output logic [NPIN-1:0]              dir_o,
   output logic                         mon_en_o,
   output logic                         ctrl_wr_o,
   output logic [NPIN-1:0][IND_AW-1:0]  link_addr_o,
   output logic [NPIN-1:0][BIT_W-1:0]   link_bit_o
);

   localparam logic [RADDR_W-1:0] CTRL_A = RADDR_W'(CTRL_ADDR);

   logic [NPIN-1:0]             link_hit;
   logic [NPIN-1:0]             dir_q;
   logic                        mon_q;
   logic [NPIN-1:0][IND_AW-1:0] laddr_q;
   logic [NPIN-1:0][BIT_W-1:0]  lbit_q;
   reg_hit_e                    hit;

   // per-entry address decode and storage
   for (genvar i = 0; i < NPIN; i++) begin : g_link
      localparam logic [RADDR_W-1:0] MY_A = RADDR_W'(LINK_BASE + i);

      assign link_hit[i] = (addr_i == MY_A);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            laddr_q[i] <= '0;
            lbit_q[i]  <= '0;
         end else if (wr_en_i && link_hit[i]) begin
            laddr_q[i] <= wdata_i[IND_AW-1:0];
            lbit_q[i]  <= wdata_i[IND_AW +: BIT_W];
         end
      end
   end

   always_comb begin
      if (addr_i == CTRL_A)  hit = HIT_CTRL;
      else if (|link_hit)    hit = HIT_LINK;
      else                   hit = HIT_NONE;
   end

   assign ctrl_wr_o = wr_en_i && (hit == HIT_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         mon_q <= 1'b0;
      end else if (ctrl_wr_o) begin
         dir_q <= wdata_i[DIR_LSB +: NPIN];
         mon_q <= wdata_i[MON_BIT];
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (hit)
         HIT_CTRL: begin
            rdata_o[LVL_LSB +: NPIN] = level_i;
            rdata_o[DIR_LSB +: NPIN] = dir_q;
            rdata_o[MON_BIT]         = mon_q;
         end
         HIT_LINK: begin
            for (int i = 0; i < NPIN; i++) begin
               if (link_hit[i]) begin
                  rdata_o[IND_AW-1:0]      = laddr_q[i];
                  rdata_o[IND_AW +: BIT_W] = lbit_q[i];
               end
            end
         end
         default: rdata_o = '0;
      endcase
   end

   assign dir_o       = dir_q;
   assign mon_en_o    = mon_q;
   assign link_addr_o = laddr_q;
   assign link_bit_o  = lbit_q;

endmodule

// File: rtl/gpio_mon_scan.sv
module gpio_mon_scan
   import gpio_mon_pkg::*;
#(
   parameter int NPIN   = 5,
   parameter int IND_AW = 8,
   parameter int BIT_W  = 3,
   localparam int IDX_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         mon_en_i,
   input  logic [NPIN-1:0][IND_AW-1:0]  link_addr_i,
   input  logic [NPIN-1:0][BIT_W-1:0]   link_bit_i,
   output logic [IND_AW-1:0]            ind_addr_o,
   output logic                         upd_o,
   output logic [IDX_W-1:0]             upd_idx_o,
   output logic [BIT_W-1:0]             upd_bit_o
);

   logic [IDX_W-1:0] ptr_q;
   logic [IDX_W-1:0] ptr_nxt;
   logic [IDX_W-1:0] idx_q;
   logic [BIT_W-1:0] bit_q;
   logic             valid_q;

   // a pointer that fills its width wraps by itself; otherwise compare
   if ((1 << IDX_W) == NPIN) begin : g_wrap_natural
      assign ptr_nxt = ptr_q + 1'b1;
   end else begin : g_wrap_compare
      assign ptr_nxt = IDX_W'(rr_next(int'(ptr_q), NPIN));
   end

   assign ind_addr_o = link_addr_i[ptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         idx_q   <= '0;
         bit_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         ptr_q   <= ptr_nxt;
         idx_q   <= ptr_q;
         bit_q   <= link_bit_i[ptr_q];
         valid_q <= mon_en_i;
      end
   end

   assign upd_o     = valid_q && mon_en_i;
   assign upd_idx_o = idx_q;
   assign upd_bit_o = bit_q;

endmodule

// File: rtl/gpio_mon.sv
module gpio_mon #(
   parameter int NPIN        = 5,
   parameter int REG_W       = 16,
   parameter int RADDR_W     = 8,
   parameter int IND_AW      = 8,
   parameter int IND_DW      = 8,
   parameter int CTRL_ADDR   = 'h20,
   parameter int LINK_BASE   = 'h21,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr_en,
   input  logic [RADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   output logic [IND_AW-1:0]  ind_addr,
   input  logic [IND_DW-1:0]  ind_rdata,
   input  logic [NPIN-1:0]    pin_in,
   output logic [NPIN-1:0]    pin_out,
   output logic [NPIN-1:0]    pin_oe
);

   localparam int BIT_W   = $clog2(IND_DW);
   localparam int IDX_W   = (NPIN > 1) ? $clog2(NPIN) : 1;
   localparam int LVL_LSB = 0;
   localparam int DIR_LSB = 8;
   localparam int MON_BIT = REG_W - 1;

   if (NPIN < 2 || NPIN > 8) begin : g_bad_npin
      $error("gpio_mon: NPIN must lie in 2..8");
   end
   if (IND_DW < 2) begin : g_bad_dw
      $error("gpio_mon: IND_DW must be at least 2");
   end
   if (DIR_LSB + NPIN > MON_BIT) begin : g_bad_ctrl
      $error("gpio_mon: control fields do not fit REG_W");
   end
   if (IND_AW + BIT_W > REG_W) begin : g_bad_link
      $error("gpio_mon: link fields do not fit REG_W");
   end
   if (LINK_BASE + NPIN > (1 << RADDR_W) || CTRL_ADDR >= (1 << RADDR_W)) begin : g_bad_map
      $error("gpio_mon: register map exceeds RADDR_W");
   end

   logic [NPIN-1:0]             level_q;
   logic [NPIN-1:0]             dir;
   logic                        mon_en;
   logic                        ctrl_wr;
   logic [NPIN-1:0][IND_AW-1:0] link_addr;
   logic [NPIN-1:0][BIT_W-1:0]  link_bit;
   logic [NPIN-1:0]             pin_sync;
   logic                        upd;
   logic [IDX_W-1:0]            upd_idx;
   logic [BIT_W-1:0]            upd_bit;
   logic                        upd_val;

   gpio_mon_regs #(
      .NPIN      (NPIN),
      .REG_W     (REG_W),
      .RADDR_W   (RADDR_W),
      .IND_AW    (IND_AW),
      .BIT_W     (BIT_W),
      .CTRL_ADDR (CTRL_ADDR),
      .LINK_BASE (LINK_BASE),
      .LVL_LSB   (LVL_LSB),
      .DIR_LSB   (DIR_LSB),
      .MON_BIT   (MON_BIT)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (reg_wr_en),
      .addr_i      (reg_addr),
      .wdata_i     (reg_wdata),
      .rdata_o     (reg_rdata),
      .level_i     (level_q),
      .dir_o       (dir),
      .mon_en_o    (mon_en),
      .ctrl_wr_o   (ctrl_wr),
      .link_addr_o (link_addr),
      .link_bit_o  (link_bit)
   );

   gpio_mon_sync #(
      .W      (NPIN),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_in),
      .q_o   (pin_sync)
   );

   gpio_mon_scan #(
      .NPIN   (NPIN),
      .IND_AW (IND_AW),
      .BIT_W  (BIT_W)
   ) u_scan (
      .clk         (clk),
      .rst_n       (rst_n),
      .mon_en_i    (mon_en),
      .link_addr_i (link_addr),
      .link_bit_i  (link_bit),
      .ind_addr_o  (ind_addr),
      .upd_o       (upd),
      .upd_idx_o   (upd_idx),
      .upd_bit_o   (upd_bit)
   );

   assign upd_val = ind_rdata[upd_bit];

   // level bits: mirror in monitor mode, else sense inputs, else host-written
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
      end else begin
         for (int i = 0; i < NPIN; i++) begin
            if (mon_en) begin
               if (upd && (upd_idx == IDX_W'(i))) level_q[i] <= upd_val;
            end else if (!dir[i]) begin
               level_q[i] <= pin_sync[i];
            end else if (ctrl_wr) begin
               level_q[i] <= reg_wdata[LVL_LSB + i];
            end
         end
      end
   end

   assign pin_oe  = dir;
   assign pin_out = level_q;

endmodule

// File: rtl/gpio_mon_chk.sv
module gpio_mon_chk #(
   parameter int NPIN   = 5,
   parameter int IND_DW = 8,
   parameter int IDX_W  = 3,
   parameter int BIT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NPIN-1:0]   pin_oe,
   input logic [NPIN-1:0]   dir,
   input logic              mon_en,
   input logic [NPIN-1:0]   level,
   input logic              upd,
   input logic [IDX_W-1:0]  upd_idx,
   input logic [BIT_W-1:0]  upd_bit,
   input logic [IND_DW-1:0] ind_rdata
);

   logic exp_val;
   assign exp_val = ind_rdata[upd_bit];

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (level == '0 && dir == '0 && !mon_en && pin_oe == '0));

   // R2
   oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe == dir);

   // R7
   scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |=> (upd_idx == (($past(upd_idx) == IDX_W'(NPIN - 1)) ? '0 : $past(upd_idx) + 1'b1)));

   // R8
   mirror_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd |=> (level[$past(upd_idx)] == $past(exp_val)));

   // R3
   monitor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en && !upd) |=> $stable(level));

endmodule

bind gpio_mon gpio_mon_chk #(
   .NPIN   (NPIN),
   .IND_DW (IND_DW),
   .IDX_W  (IDX_W),
   .BIT_W  (BIT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pin_oe    (pin_oe),
   .dir       (dir),
   .mon_en    (mon_en),
   .level     (level_q),
   .upd       (upd),
   .upd_idx   (upd_idx),
   .upd_bit   (upd_bit),
   .ind_rdata (ind_rdata)
);

// File: tb/tb_gpio_mon.sv
module tb_gpio_mon;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [7:0]  ind_addr;
   logic [7:0]  ind_rdata = '0;
   logic [4:0]  pin_in = '0;
   logic [4:0]  pin_out;
   logic [4:0]  pin_oe;

   int checks = 0;
   int failures = 0;
   logic [7:0] mem [256];

   always #5 clk = ~clk;

   gpio_mon dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr_en (reg_wr_en),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .ind_addr  (ind_addr),
      .ind_rdata (ind_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   // indirect space model with one clock of read latency
   always @(posedge clk) ind_rdata <= mem[ind_addr];

   typedef struct packed {
      logic [2:0] pin;
      logic [7:0] baddr;
      logic [2:0] bsel;
      logic [7:0] val;
      logic       exp;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{3'd0, 8'h40, 3'd0, 8'h01, 1'b1},
      '{3'd1, 8'h41, 3'd7, 8'h7F, 1'b0},
      '{3'd2, 8'h42, 3'd3, 8'h08, 1'b1},
      '{3'd3, 8'h43, 3'd5, 8'hDF, 1'b0},
      '{3'd4, 8'hFF, 3'd6, 8'h40, 1'b1},
      '{3'd0, 8'h40, 3'd0, 8'hFE, 1'b0},
      '{3'd2, 8'h00, 3'd2, 8'h04, 1'b1},
      '{3'd1, 8'h43, 3'd0, 8'hDF, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_addr  = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      logic [7:0]  seq [5];
      bit          found;
      for (int a = 0; a < 256; a++) mem[a] = 8'(a) ^ 8'hA5;

      repeat (3) @(negedge clk);
      // R1 reset state
      rd(8'h20, v); chk("R1 ctrl after reset", v, 16'h0000);
      rd(8'h21, v); chk("R1 link0 after reset", v, 16'h0000);
      chk("R1 pin_oe after reset", pin_oe, 5'h00);
      rst_n = 1'b1;

      // R3 level write ignored while pins were inputs
      wr(8'h20, 16'h151F);
      rd(8'h20, v); chk("R3 write to input pins ignored", v, 16'h1500);
      // R2 outputs now accept level writes
      wr(8'h20, 16'h151F);
      rd(8'h20, v); chk("R2 levels on output pins", v, 16'h1515);
      chk("R2 pin_oe follows direction", pin_oe, 5'h15);
      chk("R2 pin_out on outputs", pin_out & pin_oe, 5'h15);
      wr(8'h20, 16'h1504);
      chk("R2 pin_out after level change", pin_out & pin_oe, 5'h04);
      wr(8'h20, 16'h1515);

      // R4 synchronizer latency on input pins 1 and 3
      pin_in = 5'b01010;
      @(posedge clk); @(posedge clk); @(negedge clk);
      rd(8'h20, v); chk("R4 input not visible after two edges", v, 16'h1515);
      @(posedge clk); @(negedge clk);
      rd(8'h20, v); chk("R4 input visible after three edges", v, 16'h151F);

      // R6 unused control bits read 0
      wr(8'h20, 16'h75F5);
      rd(8'h20, v); chk("R6 unused control bits", v, 16'h151F);
      // R5 link field readback
      wr(8'h23, 16'hFFFF);
      rd(8'h23, v); chk("R5 link fields and unused bits", v, 16'h07FF);
      wr(8'h21, 16'h0540);
      rd(8'h21, v); chk("R5 link0 readback", v, 16'h0540);
      // R6 unused addresses
      wr(8'h26, 16'hFFFF);
      wr(8'h1F, 16'hFFFF);
      wr(8'h30, 16'hFFFF);
      rd(8'h26, v); chk("R6 address 0x26 reads 0", v, 16'h0000);
      rd(8'h1F, v); chk("R6 address 0x1F reads 0", v, 16'h0000);
      rd(8'h20, v); chk("R6 control unchanged", v, 16'h151F);
      rd(8'h22, v); chk("R6 link1 unchanged", v, 16'h0000);

      // R8 monitor table
      wr(8'h20, 16'h9515);
      foreach (VEC[i]) begin
         mem[VEC[i].baddr] = VEC[i].val;
         wr(8'h21 + 8'(VEC[i].pin), {5'b0, VEC[i].bsel, VEC[i].baddr});
         repeat (12) @(negedge clk);
         rd(8'h20, v);
         chk($sformatf("R8 vector %0d pin %0d", i, VEC[i].pin), v[VEC[i].pin], VEC[i].exp);
      end
      rd(8'h20, v); chk("R8 all mirrored levels", v, 16'h9516);
      // R10 output pins drive mirrored bits
      chk("R10 pin_out in monitor mode", pin_out & pin_oe, 5'h14);

      // R3 host level writes ignored in monitor mode
      wr(8'h20, 16'h9509);
      rd(8'h20, v); chk("R3 write ignored in monitor mode", v, 16'h9516);
      repeat (10) @(negedge clk);
      rd(8'h20, v); chk("R3 levels still mirrored", v, 16'h9516);

      // R7 scan order
      seq = '{8'h43, 8'h00, 8'h43, 8'hFF, 8'h40};
      found = 1'b0;
      for (int n = 0; n < 10 && !found; n++) begin
         @(negedge clk);
         if (ind_addr == 8'h40) found = 1'b1;
      end
      chk("R7 entry 0 address seen", found, 1'b1);
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk($sformatf("R7 scan step %0d", k), ind_addr, seq[k]);
      end

      // R9 leave monitor mode; level write in the same cycle is ignored
      wr(8'h20, 16'h1501);
      mem[8'h40] = 8'h01;
      repeat (12) @(negedge clk);
      rd(8'h20, v); chk("R9 outputs hold, inputs follow pins", v, 16'h151E);

      // R1 reset mid-run
      rst_n = 1'b0;
      @(negedge clk);
      rd(8'h20, v); chk("R1 ctrl after mid-run reset", v, 16'h0000);
      rd(8'h22, v); chk("R1 link1 after mid-run reset", v, 16'h0000);
      chk("R1 pin_oe after mid-run reset", pin_oe, 5'h00);

      finish_run();
   end

endmodule